// File: doc/BRIEF.md
# Dual-Loop Synthesizer Divider and Lock Gate

This block holds the digital counting logic of two frequency-synthesizer loops that set a picture carrier and a sound subcarrier. Every part runs in one system clock. The picture oscillator, the crystal and the sound oscillator each reach the block as a one-cycle tick strobe. The picture path counts oscillator ticks through a fixed divide-by-8 prescaler and then through a 14-bit programmable divider. The reference path divides crystal ticks by 512. The sound path divides its ticks by a ratio picked from a 2-bit standard select.

Each loop has a tri-state phase/frequency detector. The detector compares that loop's divided pulse with the shared reference pulse and drives up/down pulses to an external charge pump. A lock gate watches the width of the picture detector's pulses. It raises an in-lock flag after a run of clean reference periods, and it drops the flag at once when a pulse grows too wide. The enable for the RF output follows that flag, so no carrier leaves while the loop is still tuning. The three divided pulse trains are brought out so that test logic can watch them.

Top module: `dual_synth_core`

## Requirements
- R1: While rst_n is low, every output is 0. Reset loads a divide ratio of 256 into the picture divider and 704 into the sound divider, and marks the first reference period after reset as unclean.
- R2: ref_mon is high for exactly one cycle. It goes high in the cycle after the clock edge that samples the 512th xtal_tick of each group of 512.
- R3: pic_div_mon is high for one cycle. It goes high in the cycle after the edge that samples the 8×N-th osc_tick of a period, where N is the divide ratio in force for that period.
- R4: A new n_word value takes effect only at the next terminal count of the picture divider. The period in progress keeps its old length.
- R5: snd_div_mon is high for one cycle per sound period. The period is 576, 704, 768 or 832 snd_tick strobes for snd_sel values 0, 1, 2 and 3. A new snd_sel value takes effect at the next terminal count.
- R6: In each detector, a reference pulse sets up and the loop's divided pulse sets dn, one cycle after the monitor pulse. When up and dn are both high, both are 0 in the next cycle.
- R7: in_lock rises in the cycle after the ref_mon pulse that ends the 16th reference period in a row in which no picture pulse (up or dn) stayed high for 4 cycles in a row. The first period after reset never counts.
- R8: When pic_up or pic_dn is high for a 4th cycle in a row, in_lock is 0 in the next cycle. The clean-period count then starts again from zero.
- R9: rf_en equals in_lock in every cycle, so it is never high while the loop is out of lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One strobe per picture oscillator cycle |
| xtal_tick | input | 1 | One strobe per crystal cycle |
| snd_tick | input | 1 | One strobe per sound oscillator cycle |
| n_word | input | 14 | Picture divide ratio N |
| snd_sel | input | 2 | Sound standard select |
| pic_up | output | 1 | Picture loop pump-up pulse |
| pic_dn | output | 1 | Picture loop pump-down pulse |
| snd_up | output | 1 | Sound loop pump-up pulse |
| snd_dn | output | 1 | Sound loop pump-down pulse |
| in_lock | output | 1 | Picture loop lock flag |
| rf_en | output | 1 | RF output enable |
| pic_div_mon | output | 1 | Divided picture pulse for monitoring |
| snd_div_mon | output | 1 | Divided sound pulse for monitoring |
| ref_mon | output | 1 | Reference pulse for monitoring |

## Verification
The monitor pulses appear one cycle after the edge that samples the completing tick. The up/down pulses follow one cycle after that. The lock flag moves one cycle after either the deciding ref_mon pulse or the 4th wide pulse cycle, and rf_en changes in the same cycle as in_lock. The bench model advances on the same rising edge as the design, and every output is compared on the following falling edge, so each of these delays is checked to the exact cycle. The scenario checks measure whole pulse intervals and probe the lock flag well before and well after its due cycle, so they do not depend on the exact phase at which they sample.

// File: rtl/synth_pkg.sv
package synth_pkg;

    // Number of sound standards selectable by the 2-bit select
    localparam int unsigned SND_STD_COUNT = 4;

    // State of one tri-state detector
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_state_t;

endpackage

// File: rtl/prog_divider.sv
// Tick divider with optional fixed prescaler; ratio is sampled at terminal count
module prog_divider #(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned PRE       = 8,
    parameter int unsigned RST_RATIO = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] ratio,
    output logic             pulse_o
);
    localparam int unsigned PRE_W = (PRE > 1) ? $clog2(PRE) : 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act;
        logic             pulse;
    } div_state_t;

    div_state_t s_q, s_d;
    logic       carry;

    generate
        if (PRE > 1) begin : g_pre
            always_comb carry = tick && (s_q.pre == PRE_W'(PRE - 1));
        end else begin : g_nopre
            always_comb carry = tick;
        end
    endgenerate

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (PRE > 1 && tick) begin
            s_d.pre = (s_q.pre == PRE_W'(PRE - 1)) ? '0 : s_q.pre + 1'b1;
        end
        if (carry) begin
            if (s_q.cnt == s_q.act - 1'b1) begin
                s_d.cnt   = '0;
                s_d.act   = ratio;
                s_d.pulse = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pre   <= '0;
            s_q.cnt   <= '0;
            s_q.act   <= CNT_W'(RST_RATIO);
            s_q.pulse <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse_o = s_q.pulse;
endmodule

// File: rtl/tri_pfd.sv
// Tri-state phase/frequency detector working on one-cycle pulses
module tri_pfd
    import synth_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_p,
    input  logic div_p,
    output logic up,
    output logic dn
);
    pfd_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (s_q.up && s_q.dn) begin
            s_d.up = 1'b0;
            s_d.dn = 1'b0;
        end else begin
            s_d.up = s_q.up | ref_p;
            s_d.dn = s_q.dn | div_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign up = s_q.up;
    assign dn = s_q.dn;
endmodule

// File: rtl/lock_gate.sv
// Pulse-width based lock qualifier
module lock_gate #(
    parameter int unsigned WIDTH_LIM = 4,
    parameter int unsigned PERIODS   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up,
    input  logic dn,
    input  logic ref_p,
    output logic lock
);
    localparam int unsigned WW = (WIDTH_LIM > 1) ? $clog2(WIDTH_LIM) : 1;
    localparam int unsigned SW = $clog2(PERIODS + 1);

    typedef struct packed {
        logic [WW-1:0] width;
        logic [SW-1:0] streak;
        logic          bad;
        logic          lock;
    } lock_state_t;

    lock_state_t s_q, s_d;
    logic        hi, err;

    always_comb begin
        s_d = s_q;
        hi  = up | dn;
        err = hi && (s_q.width == WW'(WIDTH_LIM - 1));
        if (!hi) begin
            s_d.width = '0;
        end else if (!err) begin
            s_d.width = s_q.width + 1'b1;
        end
        if (err) begin
            s_d.lock   = 1'b0;
            s_d.streak = '0;
            s_d.bad    = 1'b1;
        end else if (ref_p) begin
            if (s_q.bad) begin
                s_d.bad    = 1'b0;
                s_d.streak = '0;
            end else begin
                if (s_q.streak != SW'(PERIODS)) begin
                    s_d.streak = s_q.streak + 1'b1;
                end
                if (s_q.streak >= SW'(PERIODS - 1)) begin
                    s_d.lock = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.width  <= '0;
            s_q.streak <= '0;
            s_q.bad    <= 1'b1;
            s_q.lock   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lock = s_q.lock;
endmodule

// File: rtl/dual_synth_core.sv
module dual_synth_core
    import synth_pkg::*;
#(
    parameter int unsigned N_W          = 14,
    parameter int unsigned PRE_DIV      = 8,
    parameter int unsigned N_RST        = 256,
    parameter int unsigned REF_W        = 10,
    parameter int unsigned REF_RATIO    = 512,
    parameter int unsigned SND_W        = 10,
    parameter int unsigned SND_R0       = 576,
    parameter int unsigned SND_R1       = 704,
    parameter int unsigned SND_R2       = 768,
    parameter int unsigned SND_R3       = 832,
    parameter int unsigned LOCK_WIDTH   = 4,
    parameter int unsigned LOCK_PERIODS = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           osc_tick,
    input  logic           xtal_tick,
    input  logic           snd_tick,
    input  logic [N_W-1:0] n_word,
    input  logic [1:0]     snd_sel,
    output logic           pic_up,
    output logic           pic_dn,
    output logic           snd_up,
    output logic           snd_dn,
    output logic           in_lock,
    output logic           rf_en,
    output logic           pic_div_mon,
    output logic           snd_div_mon,
    output logic           ref_mon
);
    localparam logic [SND_W-1:0] SND_TAB [SND_STD_COUNT] = '{
        SND_W'(SND_R0), SND_W'(SND_R1), SND_W'(SND_R2), SND_W'(SND_R3)
    };
    localparam int unsigned LOOPS = 2;

    logic [SND_W-1:0] snd_ratio;
    logic [LOOPS-1:0] div_p, up_w, dn_w;
    logic             ref_p, lock_w;

    assign snd_ratio = SND_TAB[snd_sel];

    prog_divider #(.CNT_W(N_W), .PRE(PRE_DIV), .RST_RATIO(N_RST)) u_pic_div (
        .clk(clk), .rst_n(rst_n), .tick(osc_tick), .ratio(n_word), .pulse_o(div_p[0])
    );

    prog_divider #(.CNT_W(SND_W), .PRE(1), .RST_RATIO(SND_R1)) u_snd_div (
        .clk(clk), .rst_n(rst_n), .tick(snd_tick), .ratio(snd_ratio), .pulse_o(div_p[1])
    );

    prog_divider #(.CNT_W(REF_W), .PRE(1), .RST_RATIO(REF_RATIO)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .tick(xtal_tick), .ratio(REF_W'(REF_RATIO)), .pulse_o(ref_p)
    );

    generate
        for (genvar g = 0; g < LOOPS; g++) begin : g_loop
            tri_pfd u_pfd (
                .clk(clk), .rst_n(rst_n), .ref_p(ref_p), .div_p(div_p[g]),
                .up(up_w[g]), .dn(dn_w[g])
            );
        end
    endgenerate

    lock_gate #(.WIDTH_LIM(LOCK_WIDTH), .PERIODS(LOCK_PERIODS)) u_lock (
        .clk(clk), .rst_n(rst_n), .up(up_w[0]), .dn(dn_w[0]), .ref_p(ref_p), .lock(lock_w)
    );

    assign pic_up      = up_w[0];
    assign pic_dn      = dn_w[0];
    assign snd_up      = up_w[1];
    assign snd_dn      = dn_w[1];
    assign in_lock     = lock_w;
    assign rf_en       = lock_w;
    assign pic_div_mon = div_p[0];
    assign snd_div_mon = div_p[1];
    assign ref_mon     = ref_p;
endmodule

// File: rtl/synth_checker.sv
module synth_checker #(
    parameter int unsigned LOCK_WIDTH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic pic_up,
    input logic pic_dn,
    input logic snd_up,
    input logic snd_dn,
    input logic in_lock,
    input logic rf_en,
    input logic ref_mon,
    input logic snd_div_mon
);
    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pic_up || pic_dn) begin
            run_q <= (run_q == 8'(LOCK_WIDTH - 1)) ? run_q : run_q + 8'd1;
        end else begin
            run_q <= '0;
        end
    end

    a_r6_pic_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pic_up && pic_dn) |=> (!pic_up && !pic_dn));
    a_r6_snd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_up && snd_dn) |=> (!snd_up && !snd_dn));
    a_r6_up_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_mon && !(pic_up && pic_dn)) |=> pic_up);
    a_r2_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
        ref_mon |=> !ref_mon);
    a_r5_snd_single: assert property (@(posedge clk) disable iff (!rst_n)
        snd_div_mon |=> !snd_div_mon);
    a_r7_rise_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_lock) |-> $past(ref_mon));
    a_r8_drop_on_wide: assert property (@(posedge clk) disable iff (!rst_n)
        ((pic_up || pic_dn) && run_q == 8'(LOCK_WIDTH - 1)) |=> !in_lock);
    a_r9_rf_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en |-> in_lock);
endmodule

bind dual_synth_core synth_checker #(.LOCK_WIDTH(LOCK_WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .pic_up(pic_up), .pic_dn(pic_dn),
    .snd_up(snd_up), .snd_dn(snd_dn), .in_lock(in_lock), .rf_en(rf_en),
    .ref_mon(ref_mon), .snd_div_mon(snd_div_mon)
);

// File: tb/sim_dual_synth_core.sv
`timescale 1ns/1ps
module sim_dual_synth_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0, xtal_tick = 1'b0, snd_tick = 1'b0;
    logic [13:0] n_word = 14'd256;
    logic [1:0]  snd_sel = 2'd1;
    logic        pic_up, pic_dn, snd_up, snd_dn, in_lock, rf_en;
    logic        pic_div_mon, snd_div_mon, ref_mon;

    int checks = 0, errors = 0;
    int cyc = 0, ncyc = 0, osc_per = 1;
    int pic_last = 0, pic_iv = 0, pic_cnt = 0;
    int snd_last = 0, snd_iv = 0, snd_cnt = 0;
    int ref_last = 0, ref_iv = 0, ref_cnt = 0;
    bit done = 0;

    // reference model state: index 0 picture, 1 sound, 2 reference
    int m_pre[3], m_cnt[3], m_act[3];
    bit m_pul[3];
    bit m_up[2], m_dn[2];
    int m_w, m_streak;
    bit m_bad, m_lock;

    always #4 clk = ~clk;

    dual_synth_core u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .xtal_tick(xtal_tick),
        .snd_tick(snd_tick), .n_word(n_word), .snd_sel(snd_sel),
        .pic_up(pic_up), .pic_dn(pic_dn), .snd_up(snd_up), .snd_dn(snd_dn),
        .in_lock(in_lock), .rf_en(rf_en), .pic_div_mon(pic_div_mon),
        .snd_div_mon(snd_div_mon), .ref_mon(ref_mon)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int snd_ratio_of(input int s);
        case (s)
            0: return 576;
            1: return 704;
            2: return 768;
            default: return 832;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // tick stimulus
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc <= 0;
            osc_tick <= 1'b0;
            xtal_tick <= 1'b0;
            snd_tick <= 1'b0;
        end else begin
            osc_tick  <= (cyc % osc_per) == 0;
            xtal_tick <= (cyc % 4) == 3;
            snd_tick  <= 1'b1;
            cyc <= cyc + 1;
        end
    end

    // behavioural reference model, advanced on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                m_pre[k] = 0; m_cnt[k] = 0; m_pul[k] = 0;
            end
            m_act[0] = 256; m_act[1] = 704; m_act[2] = 512;
            for (int g = 0; g < 2; g++) begin m_up[g] = 0; m_dn[g] = 0; end
            m_w = 0; m_streak = 0; m_bad = 1; m_lock = 0;
        end else begin
            bit hi, err;
            int pre_lim[3];
            bit tk[3];
            int rt[3];
            hi  = m_up[0] | m_dn[0];
            err = hi && (m_w == 3);
            if (err) begin
                m_lock = 0; m_streak = 0; m_bad = 1;
            end else if (m_pul[2]) begin
                if (m_bad) begin
                    m_bad = 0; m_streak = 0;
                end else begin
                    if (m_streak + 1 >= 16) m_lock = 1;
                    m_streak = (m_streak + 1 > 16) ? 16 : m_streak + 1;
                end
            end
            m_w = hi ? ((m_w == 3) ? 3 : m_w + 1) : 0;
            for (int g = 0; g < 2; g++) begin
                if (m_up[g] && m_dn[g]) begin
                    m_up[g] = 0; m_dn[g] = 0;
                end else begin
                    m_up[g] = m_up[g] | m_pul[2];
                    m_dn[g] = m_dn[g] | m_pul[g];
                end
            end
            pre_lim = '{8, 1, 1};
            tk = '{osc_tick, snd_tick, xtal_tick};
            rt = '{int'(n_word), snd_ratio_of(int'(snd_sel)), 512};
            for (int k = 0; k < 3; k++) begin
                bit carry;
                carry = tk[k] && (m_pre[k] == pre_lim[k] - 1);
                if (tk[k]) m_pre[k] = (m_pre[k] + 1) % pre_lim[k];
                m_pul[k] = 0;
                if (carry) begin
                    if (m_cnt[k] == m_act[k] - 1) begin
                        m_cnt[k] = 0; m_act[k] = rt[k]; m_pul[k] = 1;
                    end else begin
                        m_cnt[k] = m_cnt[k] + 1;
                    end
                end
            end
        end
    end

    // per-cycle comparison and interval tracking, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            ncyc++;
            chk("R2 ref_mon", ref_mon, m_pul[2]);
            chk("R3 pic_div_mon", pic_div_mon, m_pul[0]);
            chk("R5 snd_div_mon", snd_div_mon, m_pul[1]);
            chk("R6 pic_up", pic_up, m_up[0]);
            chk("R6 pic_dn", pic_dn, m_dn[0]);
            chk("R6 snd_up", snd_up, m_up[1]);
            chk("R6 snd_dn", snd_dn, m_dn[1]);
            chk("R7 in_lock", in_lock, m_lock);
            chk("R9 rf_en", rf_en, m_lock);
            if (pic_div_mon) begin pic_iv = ncyc - pic_last; pic_last = ncyc; pic_cnt++; end
            if (snd_div_mon) begin snd_iv = ncyc - snd_last; snd_last = ncyc; snd_cnt++; end
            if (ref_mon) begin ref_iv = ncyc - ref_last; ref_last = ncyc; ref_cnt++; end
        end
    end

    task automatic wait_pic(input int n);
        int c0 = pic_cnt;
        while (pic_cnt < c0 + n) step();
    endtask
    task automatic wait_snd(input int n);
        int c0 = snd_cnt;
        while (snd_cnt < c0 + n) step();
    endtask

    initial begin
        repeat (5) step();
        // R1: outputs held low in reset
        chk("R1 pic_up", pic_up, 0);
        chk("R1 pic_dn", pic_dn, 0);
        chk("R1 snd_up", snd_up, 0);
        chk("R1 in_lock", in_lock, 0);
        chk("R1 rf_en", rf_en, 0);
        chk("R1 monitors", pic_div_mon | snd_div_mon | ref_mon, 0);
        rst_n = 1'b1;

        // R2: reference period 512 crystal ticks = 2048 cycles
        while (ref_cnt < 3) step();
        chk("R2 ref interval", ref_iv, 2048);

        // R7: lock after 16 clean periods following the discarded first one
        while (cyc < 34700) step();
        chk("R7 not yet locked", in_lock, 0);
        while (cyc < 35300) step();
        chk("R7 locked", in_lock, 1);
        chk("R9 rf_en with lock", rf_en, 1);

        // R4: N change mid-period keeps the current period
        wait_pic(1);
        repeat (500) step();
        n_word = 14'd300;
        wait_pic(1);
        chk("R4 old period kept", pic_iv, 2048);
        wait_pic(1);
        chk("R3 new period 8*300", pic_iv, 2400);
        // R8: wide pulses removed lock
        chk("R8 lock dropped", in_lock, 0);
        chk("R9 rf_en off", rf_en, 0);

        // R5: sound ratios
        snd_sel = 2'd0; wait_snd(2); wait_snd(1);
        chk("R5 ratio sel0", snd_iv, 576);
        snd_sel = 2'd2; wait_snd(2); wait_snd(1);
        chk("R5 ratio sel2", snd_iv, 768);
        snd_sel = 2'd3; wait_snd(2); wait_snd(1);
        chk("R5 ratio sel3", snd_iv, 832);

        // R3: prescaler with gated oscillator ticks
        osc_per = 2;
        n_word = 14'd256;
        wait_pic(3);
        chk("R3 gated ticks period", pic_iv, 4096);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule